// File: doc/BRIEF.md
# Calibrated Watch Divider Chain

This block turns a nominal 32.768 kHz oscillator clock into the timebases of a quartz watch: a one-cycle tick each second, a one-cycle strobe each minute, and a square wave at the oscillator rate divided by 1024 (32 Hz nominal) for measuring the oscillator. A crystal that runs fast is trimmed digitally, without pulling the oscillator. Once per calibration period the chain loses a programmed number of pulses at its 8192 Hz stage. Every lost pulse delays all slower stages by one 8192 Hz slot.

A static 8-bit calibration word configures the chain. Bits [6:0] give the number of pulses removed per period, from 0 to 127. Bit 7 selects a one-minute or a two-minute period. With a one-minute period, one removed pulse trims about 2.03 ppm and the most it can trim is about 258 ppm. With a two-minute period these figures halve to about 1.017 ppm and 129 ppm. The trim can only slow the chain down. Each stage width and the seconds-per-minute count are parameters, so a scaled-down chain can be checked quickly. In the terms used below, P = 2^PRE_LOG2 clock cycles per 8192 Hz pulse, F = 2^FINE_LOG2 pulses per second, and S = SECS_PER_MIN.

Top module: `watch_cal_divider`

## Requirements
- R1: A synchronous active-high `rst` clears every stage. While `rst` is high, and in the first cycle after it, `tick_1hz`, `minute_stb` and `mon_sq` are low. The first `tick_1hz` pulse after release comes exactly P·F rising edges after the first edge that samples `rst` low.
- R2: While no correction is pending, `tick_1hz` pulses once every P·F clock cycles, and each pulse lasts one cycle.
- R3: `minute_stb` is a one-cycle pulse in the cycle after every S-th `tick_1hz` pulse.
- R4: `cal_cfg[6:0]` is the correction count n and `cal_cfg[7]` selects the period (0 = one minute, 1 = two minutes). A period boundary occurs with every `minute_stb` when bit 7 is 0, and with every second `minute_stb`, starting with the second one after reset, when bit 7 is 1.
- R5: Starting with the first 8192 Hz pulse after a period boundary, n consecutive pulses are removed. The minute that follows the boundary therefore lasts S·P·F + P·n cycles.
- R6: With bit 7 set, minute intervals alternate. The interval that ends on the boundary lasts S·P·F cycles, and the corrected interval after it lasts S·P·F + P·n cycles.
- R7: With n = 0, no pulse is removed and every minute lasts S·P·F cycles in both period modes.
- R8: The maximum count n = 127 is applied in full. The corrected minute lasts S·P·F + 127·P cycles.
- R9: `mon_sq` is a square wave with a period of 2^MON_DIV_LOG2 cycles and a high time of half that while no correction is pending.
- R10: When n is less than F, the first second after a boundary lasts P·F + P·n cycles and the next second returns to P·F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, 32.768 kHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| cal_cfg | input | 8 | Static calibration word: [6:0] count n, [7] period select |
| tick_1hz | output | 1 | One-cycle seconds tick |
| minute_stb | output | 1 | One-cycle minute strobe |
| mon_sq | output | 1 | Oscillator/1024 monitor square wave |

## Verification
The corrected interval is the hardest behaviour to reach from the ports. It only appears after a whole calibration period has passed, and in two-minute mode only on every other minute. The bench uses a scaled chain of four cycles per fine pulse, 64 pulses per second and three seconds per minute. For each calibration word it resets, waits for the first minute strobe, and times the next two minute intervals against closed-form values, so both the uncorrected and the corrected minute are covered. A separate run with a small count times individual seconds around the boundary, to show that only the first second after it is stretched.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int CORR_W = 7;

  typedef struct packed {
    logic              two_min;
    logic [CORR_W-1:0] corr_n;
  } cal_word_t;
endpackage

// File: rtl/wdc_prescaler.sv
module wdc_prescaler #(
  parameter int PRE_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic stage_pulse
);
  logic [PRE_LOG2-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  // one clock-wide pulse per stage slot (8192 Hz nominal)
  always_comb stage_pulse = &pre_cnt;
endmodule

// File: rtl/wdc_pulse_gate.sv
module wdc_pulse_gate #(
  parameter int CORR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_pulse,
  input  logic              period_edge,
  input  logic [CORR_W-1:0] corr_n,
  output logic              pass_pulse,
  output logic [CORR_W-1:0] del_cnt
);
  logic pending;

  always_comb begin
    pending    = (del_cnt != '0);
    pass_pulse = stage_pulse && !pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      del_cnt <= '0;
    end else if (period_edge) begin
      del_cnt <= corr_n;                 // a new burst starts on the next slot
    end else if (stage_pulse && pending) begin
      del_cnt <= del_cnt - 1'b1;         // this slot is swallowed
    end
  end
endmodule

// File: rtl/wdc_fine_div.sv
module wdc_fine_div #(
  parameter int FINE_LOG2 = 13,
  parameter int MON_BIT   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pass_pulse,
  output logic [FINE_LOG2-1:0] fine_cnt,
  output logic                 tick_q,
  output logic                 mon_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fine_cnt <= '0;
      tick_q   <= 1'b0;
      mon_q    <= 1'b0;
    end else begin
      tick_q <= pass_pulse && (&fine_cnt);
      mon_q  <= fine_cnt[MON_BIT];
      if (pass_pulse) fine_cnt <= fine_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdc_period_ctr.sv
module wdc_period_ctr #(
  parameter int SECS_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic two_min,
  output logic minute_q,
  output logic edge_q
);
  localparam int SEC_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS_PER_MIN - 1);

  logic [SEC_W-1:0] sec_cnt;
  logic             odd_min;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt  <= '0;
      odd_min  <= 1'b0;
      minute_q <= 1'b0;
      edge_q   <= 1'b0;
    end else begin
      minute_q <= 1'b0;
      edge_q   <= 1'b0;
      if (tick) begin
        if (sec_cnt == SEC_LAST) begin
          sec_cnt  <= '0;
          minute_q <= 1'b1;
          if (!two_min || odd_min) begin
            edge_q  <= 1'b1;
            odd_min <= 1'b0;
          end else begin
            odd_min <= 1'b1;
          end
        end else begin
          sec_cnt <= sec_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/watch_cal_divider.sv
module watch_cal_divider
  import wdc_pkg::*;
#(
  parameter int PRE_LOG2     = 2,
  parameter int FINE_LOG2    = 13,
  parameter int MON_DIV_LOG2 = 10,
  parameter int SECS_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cal_cfg,
  output logic       tick_1hz,
  output logic       minute_stb,
  output logic       mon_sq
);
  localparam int MON_BIT = MON_DIV_LOG2 - 1 - PRE_LOG2;

  cal_word_t         cfg_w;
  logic              stage_pulse;
  logic              pass_pulse;
  logic              period_edge;
  logic [CORR_W-1:0] del_cnt;
  logic [FINE_LOG2-1:0] fine_cnt;

  always_comb cfg_w = cal_word_t'(cal_cfg);

  wdc_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .stage_pulse(stage_pulse)
  );

  wdc_pulse_gate #(.CORR_W(CORR_W)) u_gate (
    .clk(clk), .rst(rst), .stage_pulse(stage_pulse),
    .period_edge(period_edge), .corr_n(cfg_w.corr_n),
    .pass_pulse(pass_pulse), .del_cnt(del_cnt)
  );

  wdc_fine_div #(.FINE_LOG2(FINE_LOG2), .MON_BIT(MON_BIT)) u_fine (
    .clk(clk), .rst(rst), .pass_pulse(pass_pulse),
    .fine_cnt(fine_cnt), .tick_q(tick_1hz), .mon_q(mon_sq)
  );

  wdc_period_ctr #(.SECS_PER_MIN(SECS_PER_MIN)) u_period (
    .clk(clk), .rst(rst), .tick(tick_1hz), .two_min(cfg_w.two_min),
    .minute_q(minute_stb), .edge_q(period_edge)
  );
endmodule

// File: rtl/wdc_checker.sv
module wdc_checker #(
  parameter int FINE_W = 13,
  parameter int CORR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              stage_pulse,
  input logic              period_edge,
  input logic [CORR_W-1:0] del_cnt,
  input logic [CORR_W-1:0] corr_n,
  input logic [FINE_W-1:0] fine_cnt,
  input logic              tick_1hz,
  input logic              minute_stb
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!tick_1hz && !minute_stb && del_cnt == '0));

  p_tick_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    tick_1hz |=> !tick_1hz);

  p_fine_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (stage_pulse && del_cnt == '0) |=> fine_cnt == $past(fine_cnt) + 1'b1);

  p_minute_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
    minute_stb |-> $past(tick_1hz));

  p_edge_on_minute_r4: assert property (@(posedge clk) disable iff (rst)
    period_edge |-> minute_stb);

  p_burst_load_r5: assert property (@(posedge clk) disable iff (rst)
    period_edge |=> del_cnt == $past(corr_n));

  p_burst_countdown_r5: assert property (@(posedge clk) disable iff (rst)
    (stage_pulse && del_cnt != '0 && !period_edge) |=> del_cnt == $past(del_cnt) - 1'b1);

  p_fine_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (del_cnt != '0 && !period_edge) |=> $stable(fine_cnt));

  p_idle_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (del_cnt == '0 && !period_edge) |=> del_cnt == '0);
endmodule

bind watch_cal_divider wdc_checker #(.FINE_W(FINE_LOG2), .CORR_W(wdc_pkg::CORR_W)) u_chk (
  .clk(clk), .rst(rst), .stage_pulse(stage_pulse), .period_edge(period_edge),
  .del_cnt(del_cnt), .corr_n(cfg_w.corr_n), .fine_cnt(fine_cnt),
  .tick_1hz(tick_1hz), .minute_stb(minute_stb)
);

// File: tb/sim_watch_cal_divider.sv
`timescale 1ns/1ps
module sim_watch_cal_divider;
  // scaled chain: P = 4, F = 64, S = 3 -> second 256, minute 768 cycles
  localparam int PRE_LOG2 = 2;
  localparam int FINE_LOG2 = 6;
  localparam int MON_DIV_LOG2 = 5;
  localparam int SECS = 3;
  localparam int NV = 8;

  localparam logic [7:0] V_CFG [NV] = '{8'h00, 8'h01, 8'h05, 8'h40, 8'h7F, 8'h80, 8'h83, 8'hFF};
  localparam int V_EXP1 [NV] = '{768, 772, 788, 1024, 1276, 768, 768, 768};
  localparam int V_EXP2 [NV] = '{768, 772, 788, 1024, 1276, 768, 780, 1276};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cal_cfg = 8'h00;
  logic tick_1hz, minute_stb, mon_sq;
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  watch_cal_divider #(
    .PRE_LOG2(PRE_LOG2), .FINE_LOG2(FINE_LOG2),
    .MON_DIV_LOG2(MON_DIV_LOG2), .SECS_PER_MIN(SECS)
  ) u0 (
    .clk(clk), .rst(rst), .cal_cfg(cal_cfg),
    .tick_1hz(tick_1hz), .minute_stb(minute_stb), .mon_sq(mon_sq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [7:0] cfg);
    @(negedge clk);
    cal_cfg = cfg;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_minute(output int t);
    do @(negedge clk); while (!minute_stb);
    t = cyc;
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!tick_1hz);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int m1, m2, m3, t1, t2, t3, t4, t5, base, r1, f1, r2;
    // table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      apply_reset(V_CFG[i]);
      wait_minute(m1);
      wait_minute(m2);
      wait_minute(m3);
      chk($sformatf("R4/R5/R6 cfg=%02h first interval", V_CFG[i]), m2 - m1, V_EXP1[i]);
      chk($sformatf("R5/R7/R8 cfg=%02h second interval", V_CFG[i]), m3 - m2, V_EXP2[i]);
    end

    // R1: outputs low during reset
    @(negedge clk);
    rst = 1'b1;
    cal_cfg = 8'h00;
    @(negedge clk);
    @(negedge clk);
    chk("R1 tick in reset", int'(tick_1hz), 0);
    chk("R1 minute in reset", int'(minute_stb), 0);
    chk("R1 monitor in reset", int'(mon_sq), 0);
    rst = 1'b0;
    base = cyc;
    wait_tick(t1);
    chk("R1 first tick after release", t1 - base, 256);

    // R2, R3, R10: second lengths around a boundary with n=5
    apply_reset(8'h05);
    wait_tick(t1);
    wait_tick(t2);
    wait_tick(t3);
    chk("R2 uncorrected second", t2 - t1, 256);
    wait_minute(m1);
    chk("R3 minute strobe one cycle after tick", m1 - t3, 1);
    wait_tick(t4);
    wait_tick(t5);
    chk("R10 stretched second after boundary", t4 - t3, 276);
    chk("R10 following second nominal", t5 - t4, 256);
    @(negedge clk);
    chk("R2 tick single cycle", int'(tick_1hz), 0);

    // R9: monitor square wave with no correction
    apply_reset(8'h00);
    repeat (100) @(negedge clk);
    do @(negedge clk); while (mon_sq);
    do @(negedge clk); while (!mon_sq);
    r1 = cyc;
    do @(negedge clk); while (mon_sq);
    f1 = cyc;
    do @(negedge clk); while (!mon_sq);
    r2 = cyc;
    chk("R9 monitor high time", f1 - r1, 16);
    chk("R9 monitor period", r2 - r1, 32);

    // R1: reset in the middle of a second restarts the chain
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 tick after mid-run reset", int'(tick_1hz), 0);
    base = cyc;
    wait_tick(t1);
    chk("R1 first tick after mid-run reset", t1 - base, 256);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule